// File: doc/BRIEF.md
# Rounding Saturating Sample Down-Scaler

This block narrows wide unsigned converter samples to byte-sized values, one sample per clock, ahead of a byte-serial link. In rounding mode it rounds to the nearest output step. It does this by adding half an output LSB, taken from the highest discarded bit, to the kept upper bits. When that addition would carry out of the output width, the block clamps to the largest output code instead of wrapping to zero. In truncation mode it keeps only the upper bits.

Samples arrive with a valid strobe. The result comes out of a register one clock later, with its own valid strobe. Between valid samples the output register keeps its last value. The input width and output width are parameters. The number of dropped bits follows from them.

Top module: `sample_downscaler`

## Requirements
- R1: While synchronous reset `rst` is high at a rising edge, the next cycle shows `out_valid` = 0 and `out_data` = 0.
- R2: `out_valid` in any cycle equals `in_valid` one clock earlier, which gives exactly one cycle of latency.
- R3: With `mode_round` = 1 and a valid input x, the output one clock later is (x + 32) >> 6, for every x below 0x3FE0.
- R4: With `mode_round` = 1, every valid input from 0x3FE0 to 0x3FFF gives 0xFF one clock later, with no wrap to 0x00.
- R5: With `mode_round` = 0 and a valid input x, the output one clock later is x >> 6, which is bits 13..6 of x.
- R6: A cycle with `in_valid` = 0 leaves `out_data` unchanged, whatever `in_data` and `mode_round` carry.
- R7: Within one mode, a larger input never gives a smaller output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_round | input | 1 | 1 = round to nearest with clamping, 0 = truncate |
| in_valid | input | 1 | Qualifies `in_data` in this cycle |
| in_data | input | 14 | Unsigned wide sample |
| out_valid | output | 1 | Qualifies `out_data`, one clock after `in_valid` |
| out_data | output | 8 | Scaled byte |

## Verification
The bench uses the default widths, 14 bits in and 8 bits out. At these widths every one of the 16384 input codes can be driven in both modes, so each rounding boundary, every code in the clamping band and the whole monotonic ordering are checked rather than sampled. Idle cycles are placed regularly in the sweep. During them `in_data` and the mode toggle while the held output byte is checked.

// File: rtl/ds_pkg.sv
package ds_pkg;
    typedef enum logic {
        DS_TRUNC = 1'b0,
        DS_ROUND = 1'b1
    } ds_mode_e;
endpackage

// File: rtl/ds_narrow.sv
module ds_narrow #(
    parameter int IN_W  = 14,
    parameter int OUT_W = 8
) (
    input  logic             mode_round,
    input  logic [IN_W-1:0]  sample,
    output logic [OUT_W-1:0] scaled
);
    import ds_pkg::*;
    localparam int DROP = IN_W - OUT_W;

    ds_mode_e mode;
    assign mode = ds_mode_e'(mode_round);

    generate
        if (DROP > 0) begin : g_drop
            logic [OUT_W-1:0] upper;
            logic             half_bit;
            logic [OUT_W:0]   sum;
            assign upper    = sample[IN_W-1:DROP];
            assign half_bit = sample[DROP-1];
            assign sum      = {1'b0, upper} + {{OUT_W{1'b0}}, half_bit};
            always_comb begin
                unique case (mode)
                    DS_ROUND: scaled = sum[OUT_W] ? {OUT_W{1'b1}} : sum[OUT_W-1:0];
                    DS_TRUNC: scaled = upper;
                    default:  scaled = upper;
                endcase
            end
        end else begin : g_pass
            assign scaled = sample[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/ds_outreg.sv
module ds_outreg #(
    parameter int OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [OUT_W-1:0] d,
    output logic             q_valid,
    output logic [OUT_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q       <= '0;
        end else begin
            q_valid <= load;
            if (load) q <= d;
        end
    end
endmodule

// File: rtl/sample_downscaler.sv
module sample_downscaler #(
    parameter int IN_W  = 14,
    parameter int OUT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_round,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_data
);
    logic [OUT_W-1:0] scaled;

    ds_narrow #(.IN_W(IN_W), .OUT_W(OUT_W)) narrow_i (
        .mode_round (mode_round),
        .sample     (in_data),
        .scaled     (scaled)
    );

    ds_outreg #(.OUT_W(OUT_W)) outreg_i (
        .clk     (clk),
        .rst     (rst),
        .load    (in_valid),
        .d       (scaled),
        .q_valid (out_valid),
        .q       (out_data)
    );
endmodule

// File: rtl/sample_downscaler_chk.sv
module sample_downscaler_chk #(
    parameter int IN_W  = 14,
    parameter int OUT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             mode_round,
    input logic             in_valid,
    input logic [IN_W-1:0]  in_data,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data
);
    localparam int DROP = IN_W - OUT_W;
    localparam logic [IN_W-1:0] SAT_FROM = {{(OUT_W+1){1'b1}}, {(DROP-1){1'b0}}};

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r4_clamp_band: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode_round && in_data >= SAT_FROM) |=> (out_data == {OUT_W{1'b1}}));

    a_r5_trunc_bits: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mode_round) |=> (out_data == $past(in_data[IN_W-1:DROP])));

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));
endmodule

bind sample_downscaler sample_downscaler_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .mode_round (mode_round),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .out_valid  (out_valid),
    .out_data   (out_data)
);

// File: tb/sample_downscaler_tb_top.sv
`timescale 1ns/1ps
module sample_downscaler_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_round = 1'b0;
    logic        in_valid = 1'b0;
    logic [13:0] in_data = '0;
    logic        out_valid;
    logic [7:0]  out_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    sample_downscaler dut_i (
        .clk(clk), .rst(rst), .mode_round(mode_round),
        .in_valid(in_valid), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int expect_val(input int x, input bit rnd);
        int e;
        if (rnd) begin
            e = (x + 32) >> 6;
            if (e > 255) e = 255;
        end else begin
            e = x >> 6;
        end
        return e;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int prev;
        int held;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 14'h3FFF;
        mode_round = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 out_valid after reset", out_valid, 0);
        check("R1 out_data after reset", out_data, 0);
        rst = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            prev = -1;
            for (int x = 0; x < 16384; x++) begin
                mode_round = m[0];
                in_valid = 1'b1;
                in_data = x[13:0];
                @(negedge clk);
                check("R2 out_valid follows in_valid", out_valid, 1);
                if (m == 0)
                    check("R5 truncation", out_data, expect_val(x, 1'b0));
                else if (x >= 16352)
                    check("R4 clamp band", out_data, 255);
                else
                    check("R3 rounding", out_data, expect_val(x, 1'b1));
                if (prev >= 0 && int'(out_data) < prev)
                    check("R7 monotonic", out_data, prev);
                else
                    checks++;
                prev = out_data;
                if ((x % 1024) == 1023) begin
                    held = out_data;
                    in_valid = 1'b0;
                    in_data = ~in_data;
                    mode_round = ~mode_round;
                    @(negedge clk);
                    check("R2 idle gives out_valid low", out_valid, 0);
                    check("R6 idle holds out_data", out_data, held);
                end
            end
        end
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule